// File: doc/BRIEF.md
# PHY Strap and Mode Configuration Controller

This block sets the operating mode of a fast-Ethernet PHY. On the first clock after reset is released, it captures a 5-bit device address and three hardware strap inputs: autonegotiation, full duplex and 100 Mbps. The strap values are loaded into the software-visible register copies. The power-up state of the MII disable bit depends on the captured address. After that, software may change any setting through a simple register write port. Each write takes priority over the strap value it replaces.

A repeater input pin overrides these settings while it is high. It forces TXEN-to-CRS loopback off, autonegotiation off, half duplex and 100 Mbps, whatever the strap inputs and register copies hold. The resolved modes are registered outputs.

When the MII is disabled, the block gates the MII-side data and the transmit path. The output enable goes low, the data and transmit enable are forced to zero, and a transmit-inhibit flag goes high for the line drivers. Setting the coder bypass bit selects the five-bit data path. When the bypass bit is clear, bit 4 of every data path is forced to zero.

Top module: `phy_mode_ctrl`

## Requirements
- R1: On the first rising clock edge after rst_ni is released, `phy_addr_i` is captured into `phy_addr_o`. The captured value is then held, whatever later changes occur on `phy_addr_i`.
- R2: If the captured address is 5'b11111, the MII disable bit (control register bit 3) initialises to 1. For any other address it initialises to 0.
- R3: While the resolved MII disable is 1, the following hold: `mii_oe_o` is 0, `tx_inhibit_o` is 1, `core_tx_en_o` is 0, and `core_txd_o` and `mii_rxd_o` are all zeros. While it is 0, `mii_oe_o` is 1 and the inputs pass through.
- R4: While `repeater_i` is 1, the resolved outputs are forced to these values: `crs_loop_en_o`=0, `aneg_en_o`=0, `full_duplex_o`=0 and `speed100_o`=1.
- R5: While `repeater_i` is 1, the strap inputs and the register copies of autonegotiation, duplex and speed have no effect on the resolved outputs.
- R6: Config register bit 1 (coder bypass) drives `five_bit_o`. When bypass is 0, bit 4 of `core_txd_o` and `mii_rxd_o` is forced to 0. When bypass is 1, bit 4 passes through.
- R7: Config register bit 0 (loopback disable) set to 1 makes `crs_loop_en_o` 0 even when `repeater_i` is 0.
- R8: Control register bits drive the resolved outputs while `repeater_i` is 0. The bits are bit 0 autonegotiation, bit 1 full duplex, bit 2 100 Mbps and bit 3 MII disable. They are loaded from the straps at initialisation and replaced by writes.
- R9: A write is stored on the rising edge where `reg_wr_i` is high. Resolved outputs reflect the write, and any change on `repeater_i`, on the next rising edge after that.
- R10: Reading `reg_addr_i` returns stored bits, not forced values. Address 0 returns {4'b0, ctrl[3:0]}, address 1 returns {6'b0, cfg[1:0]}, address 2 returns {3'b0, captured address}, and address 3 returns 0.
- R11: While in reset, the resolved outputs hold these values: `mii_dis_o`=1, `mii_oe_o`=0, `aneg_en_o`=0, `full_duplex_o`=0, `speed100_o`=0, `crs_loop_en_o`=0 and `five_bit_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset; restarts strap capture |
| phy_addr_i | input | 5 | Device address strap pins |
| strap_aneg_i | input | 1 | Autonegotiation strap |
| strap_fdx_i | input | 1 | Full-duplex strap |
| strap_spd100_i | input | 1 | 100 Mbps strap |
| repeater_i | input | 1 | Repeater mode pin |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data (combinational) |
| phy_addr_o | output | 5 | Captured device address |
| aneg_en_o | output | 1 | Resolved autonegotiation enable |
| full_duplex_o | output | 1 | Resolved full duplex |
| speed100_o | output | 1 | Resolved 100 Mbps select |
| crs_loop_en_o | output | 1 | Resolved TXEN-to-CRS loopback enable |
| five_bit_o | output | 1 | Five-bit data path selected |
| mii_dis_o | output | 1 | Resolved MII disable |
| tx_inhibit_o | output | 1 | Inhibit twisted-pair and fiber transmit |
| mii_oe_o | output | 1 | MII output enable (0 = high impedance) |
| mii_txd_i | input | 5 | Transmit data from the MII |
| mii_tx_en_i | input | 1 | Transmit enable from the MII |
| core_txd_o | output | 5 | Gated transmit data to the PHY core |
| core_tx_en_o | output | 1 | Gated transmit enable to the PHY core |
| core_rxd_i | input | 5 | Receive data from the PHY core |
| mii_rxd_o | output | 5 | Gated receive data to the MII |

## Verification
On every cycle, the assertions check the following:
- the captured address stays stable;
- the MII disable bit takes the address-dependent value at initialisation;
- the repeater pin forces the modes;
- the loopback-disable bit holds loopback off;
- a disabled interface holds its data and enables at zero;
- bit 4 is masked whenever the path is four bits wide.

The bench's scenarios cover the rest:
- that strap values actually reach the register copies;
- that a write overrides a strap;
- that readback shows stored rather than forced bits;
- that straps stay masked across a repeater reset;
- the exact cycle in which the resolved outputs change.

// File: rtl/phy_mode_pkg.sv
package phy_mode_pkg;
  localparam int unsigned ADDR_W = 5;
  localparam int unsigned DATA_W = 5;
  localparam int unsigned REG_W  = 8;
  localparam int unsigned RA_W   = 2;
  localparam logic [ADDR_W-1:0] SHARED_ADDR = '1;

  typedef enum logic [RA_W-1:0] {
    RA_CTRL = 2'd0,
    RA_CFG  = 2'd1,
    RA_ADDR = 2'd2,
    RA_NONE = 2'd3
  } reg_sel_e;

  typedef struct packed {
    logic mii_dis;
    logic spd100;
    logic fdx;
    logic aneg;
  } ctrl_t;

  typedef struct packed {
    logic bypass;
    logic loop_dis;
  } cfg_t;
endpackage

// File: rtl/phy_strap_latch.sv
module phy_strap_latch
  import phy_mode_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_pins_i,
  output logic              load_o,
  output logic [ADDR_W-1:0] addr_o
);
  logic init_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      init_q <= 1'b0;
      addr_o <= '0;
    end else if (!init_q) begin
      init_q <= 1'b1;
      addr_o <= addr_pins_i;
    end
  end

  assign load_o = ~init_q;

  p_addr_hold_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni) && $past(init_q) |-> $stable(addr_o));
endmodule

// File: rtl/phy_mode_regs.sv
module phy_mode_regs
  import phy_mode_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] addr_pins_i,
  input  logic [ADDR_W-1:0] addr_q_i,
  input  logic              strap_aneg_i,
  input  logic              strap_fdx_i,
  input  logic              strap_spd100_i,
  input  logic              wr_i,
  input  logic [RA_W-1:0]   ra_i,
  input  logic [REG_W-1:0]  wdata_i,
  output logic [REG_W-1:0]  rdata_o,
  output ctrl_t             ctrl_o,
  output cfg_t              cfg_o
);
  localparam int unsigned CTRL_W = $bits(ctrl_t);
  localparam int unsigned CFG_W  = $bits(cfg_t);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_o <= '{mii_dis: 1'b1, spd100: 1'b0, fdx: 1'b0, aneg: 1'b0};
      cfg_o  <= '0;
    end else if (load_i) begin
      ctrl_o.aneg    <= strap_aneg_i;
      ctrl_o.fdx     <= strap_fdx_i;
      ctrl_o.spd100  <= strap_spd100_i;
      ctrl_o.mii_dis <= (addr_pins_i == SHARED_ADDR);
    end else if (wr_i) begin
      case (reg_sel_e'(ra_i))
        RA_CTRL: ctrl_o <= ctrl_t'(wdata_i[CTRL_W-1:0]);
        RA_CFG:  cfg_o  <= cfg_t'(wdata_i[CFG_W-1:0]);
        default: ;
      endcase
    end
  end

  always_comb begin
    rdata_o = '0;
    case (reg_sel_e'(ra_i))
      RA_CTRL: rdata_o[CTRL_W-1:0] = ctrl_o;
      RA_CFG:  rdata_o[CFG_W-1:0]  = cfg_o;
      RA_ADDR: rdata_o[ADDR_W-1:0] = addr_q_i;
      default: rdata_o = '0;
    endcase
  end

  p_dis_default_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni) && $past(load_i) |-> ctrl_o.mii_dis == ($past(addr_pins_i) == SHARED_ADDR));
endmodule

// File: rtl/phy_mode_resolve.sv
module phy_mode_resolve
  import phy_mode_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  repeater_i,
  input  ctrl_t ctrl_i,
  input  cfg_t  cfg_i,
  output logic  aneg_o,
  output logic  fdx_o,
  output logic  spd100_o,
  output logic  loop_en_o,
  output logic  five_bit_o,
  output logic  mii_dis_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      aneg_o     <= 1'b0;
      fdx_o      <= 1'b0;
      spd100_o   <= 1'b0;
      loop_en_o  <= 1'b0;
      five_bit_o <= 1'b0;
      mii_dis_o  <= 1'b1;
    end else begin
      // repeater pin masks both straps and register copies
      aneg_o     <= repeater_i ? 1'b0 : ctrl_i.aneg;
      fdx_o      <= repeater_i ? 1'b0 : ctrl_i.fdx;
      spd100_o   <= repeater_i ? 1'b1 : ctrl_i.spd100;
      loop_en_o  <= ~(repeater_i | cfg_i.loop_dis);
      five_bit_o <= cfg_i.bypass;
      mii_dis_o  <= ctrl_i.mii_dis;
    end
  end

  p_rptr_force_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni) && $past(repeater_i) |-> !aneg_o && !fdx_o && spd100_o && !loop_en_o);

  p_loop_dis_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni) && $past(cfg_i.loop_dis) |-> !loop_en_o);
endmodule

// File: rtl/phy_mii_gate.sv
module phy_mii_gate
  import phy_mode_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mii_dis_i,
  input  logic              five_bit_i,
  input  logic [DATA_W-1:0] mii_txd_i,
  input  logic              mii_tx_en_i,
  input  logic [DATA_W-1:0] core_rxd_i,
  output logic [DATA_W-1:0] core_txd_o,
  output logic              core_tx_en_o,
  output logic [DATA_W-1:0] mii_rxd_o,
  output logic              mii_oe_o,
  output logic              tx_inhibit_o
);
  logic [DATA_W-1:0] lane_mask;

  generate
    for (genvar i = 0; i < DATA_W; i++) begin : g_mask
      if (i == DATA_W - 1) begin : g_top
        assign lane_mask[i] = ~mii_dis_i & five_bit_i;
      end else begin : g_low
        assign lane_mask[i] = ~mii_dis_i;
      end
    end
  endgenerate

  assign core_txd_o   = mii_txd_i & lane_mask;
  assign mii_rxd_o    = core_rxd_i & lane_mask;
  assign core_tx_en_o = mii_tx_en_i & ~mii_dis_i;
  assign mii_oe_o     = ~mii_dis_i;
  assign tx_inhibit_o = mii_dis_i;

  p_dis_quiet_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_inhibit_o |-> !mii_oe_o && !core_tx_en_o && (core_txd_o == '0) && (mii_rxd_o == '0));

  p_four_bit_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !five_bit_i |-> !core_txd_o[DATA_W-1] && !mii_rxd_o[DATA_W-1]);
endmodule

// File: rtl/phy_mode_ctrl.sv
module phy_mode_ctrl
  import phy_mode_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] phy_addr_i,
  input  logic              strap_aneg_i,
  input  logic              strap_fdx_i,
  input  logic              strap_spd100_i,
  input  logic              repeater_i,
  input  logic              reg_wr_i,
  input  logic [RA_W-1:0]   reg_addr_i,
  input  logic [REG_W-1:0]  reg_wdata_i,
  output logic [REG_W-1:0]  reg_rdata_o,
  output logic [ADDR_W-1:0] phy_addr_o,
  output logic              aneg_en_o,
  output logic              full_duplex_o,
  output logic              speed100_o,
  output logic              crs_loop_en_o,
  output logic              five_bit_o,
  output logic              mii_dis_o,
  output logic              tx_inhibit_o,
  output logic              mii_oe_o,
  input  logic [DATA_W-1:0] mii_txd_i,
  input  logic              mii_tx_en_i,
  output logic [DATA_W-1:0] core_txd_o,
  output logic              core_tx_en_o,
  input  logic [DATA_W-1:0] core_rxd_i,
  output logic [DATA_W-1:0] mii_rxd_o
);
  logic  load;
  ctrl_t ctrl;
  cfg_t  cfg;

  phy_strap_latch u_latch (
    .clk_i, .rst_ni,
    .addr_pins_i (phy_addr_i),
    .load_o      (load),
    .addr_o      (phy_addr_o)
  );

  phy_mode_regs u_regs (
    .clk_i, .rst_ni,
    .load_i         (load),
    .addr_pins_i    (phy_addr_i),
    .addr_q_i       (phy_addr_o),
    .strap_aneg_i,
    .strap_fdx_i,
    .strap_spd100_i,
    .wr_i           (reg_wr_i),
    .ra_i           (reg_addr_i),
    .wdata_i        (reg_wdata_i),
    .rdata_o        (reg_rdata_o),
    .ctrl_o         (ctrl),
    .cfg_o          (cfg)
  );

  phy_mode_resolve u_resolve (
    .clk_i, .rst_ni,
    .repeater_i,
    .ctrl_i     (ctrl),
    .cfg_i      (cfg),
    .aneg_o     (aneg_en_o),
    .fdx_o      (full_duplex_o),
    .spd100_o   (speed100_o),
    .loop_en_o  (crs_loop_en_o),
    .five_bit_o (five_bit_o),
    .mii_dis_o  (mii_dis_o)
  );

  phy_mii_gate u_gate (
    .clk_i, .rst_ni,
    .mii_dis_i    (mii_dis_o),
    .five_bit_i   (five_bit_o),
    .mii_txd_i,
    .mii_tx_en_i,
    .core_rxd_i,
    .core_txd_o,
    .core_tx_en_o,
    .mii_rxd_o,
    .mii_oe_o,
    .tx_inhibit_o
  );
endmodule

// File: tb/tb_phy_mode_ctrl.sv
module tb_phy_mode_ctrl;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_ni = 0;
  logic [4:0] phy_addr = 0;
  logic s_aneg = 0, s_fdx = 0, s_spd = 0, rptr = 0;
  logic wr = 0;
  logic [1:0] ra = 0;
  logic [7:0] wd = 0, rd;
  logic [4:0] addr_o, txd = 0, rxd = 0, core_txd, mii_rxd;
  logic aneg, fdx, spd, loop_en, five, dis, inh, oe, tx_en = 0, core_tx_en;

  int n_tests = 0, n_fail = 0;
  logic [3:0] m_ctrl;
  logic [1:0] m_cfg;
  logic [4:0] m_addr;

  phy_mode_ctrl dut (
    .clk_i(clk), .rst_ni, .phy_addr_i(phy_addr), .strap_aneg_i(s_aneg),
    .strap_fdx_i(s_fdx), .strap_spd100_i(s_spd), .repeater_i(rptr),
    .reg_wr_i(wr), .reg_addr_i(ra), .reg_wdata_i(wd), .reg_rdata_o(rd),
    .phy_addr_o(addr_o), .aneg_en_o(aneg), .full_duplex_o(fdx), .speed100_o(spd),
    .crs_loop_en_o(loop_en), .five_bit_o(five), .mii_dis_o(dis), .tx_inhibit_o(inh),
    .mii_oe_o(oe), .mii_txd_i(txd), .mii_tx_en_i(tx_en), .core_txd_o(core_txd),
    .core_tx_en_o(core_tx_en), .core_rxd_i(rxd), .mii_rxd_o(mii_rxd)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  initial begin
    #(CLK_PERIOD * 150000);
    n_fail++;
    $display("FAIL watchdog: run did not finish");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // expected {aneg,fdx,spd,loop_en,five,dis}
  function automatic logic [5:0] exp_modes(input logic r, input logic [3:0] c, input logic [1:0] g);
    exp_modes = {r ? 1'b0 : c[0], r ? 1'b0 : c[1], r ? 1'b1 : c[2], ~(r | g[0]), g[1], c[3]};
  endfunction

  function automatic logic [10:0] exp_gate(input logic d, input logic f, input logic [4:0] t,
                                           input logic e, input logic [4:0] x);
    logic [4:0] m;
    m = d ? 5'b0 : {f, 4'hf};
    exp_gate = {t & m, e & ~d, x & m};
  endfunction

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset(input logic [4:0] a, input logic sa, input logic sf, input logic ss);
    @(negedge clk);
    rst_ni = 0; phy_addr = a; s_aneg = sa; s_fdx = sf; s_spd = ss;
    cyc(2);
    rst_ni = 1;
    cyc(2);
    m_ctrl = {a == 5'h1f, ss, sf, sa}; m_cfg = 2'b00; m_addr = a;
  endtask

  task automatic wr_reg(input logic [1:0] a, input logic [7:0] d);
    wr = 1; ra = a; wd = d;
    cyc(1);
    wr = 0;
    if (a == 2'd0) m_ctrl = d[3:0];
    if (a == 2'd1) m_cfg = d[1:0];
    cyc(1);
  endtask

  task automatic chk_modes(input string req);
    chk(req, {aneg, fdx, spd, loop_en, five, dis}, exp_modes(rptr, m_ctrl, m_cfg));
  endtask

  task automatic chk_regs(input string req);
    ra = 0; #1 chk(req, rd, {4'b0, m_ctrl});
    ra = 1; #1 chk(req, rd, {6'b0, m_cfg});
    ra = 2; #1 chk(req, rd, {3'b0, m_addr});
    ra = 3; #1 chk(req, rd, 8'h00);
  endtask

  initial begin
    // R11 reset state
    cyc(2);
    chk("R11", {aneg, fdx, spd, loop_en, five, dis, oe}, 7'b0000010);

    // R1/R2/R8 strap capture with ordinary address
    do_reset(5'h0a, 1, 1, 0);
    chk("R1", addr_o, 5'h0a);
    chk("R2", dis, 0);
    chk_modes("R8");
    chk_regs("R10");
    phy_addr = 5'h13; cyc(3);
    chk("R1", addr_o, 5'h0a);

    // R2/R3 shared address powers up disabled
    do_reset(5'h1f, 0, 0, 1);
    chk("R2", dis, 1);
    txd = 5'h1f; tx_en = 1; rxd = 5'h1f; #1;
    chk("R3", {oe, inh, core_txd, core_tx_en, mii_rxd}, {2'b01, 11'b0});

    // R9 write timing: stored at edge, outputs one edge later
    @(negedge clk);
    wr = 1; ra = 0; wd = 8'h05;
    @(posedge clk); #1;
    wr = 0;
    chk("R9", dis, 1);
    @(posedge clk); #1;
    chk("R9", {aneg, spd, dis}, 3'b110);
    m_ctrl = 4'h5;
    @(negedge clk);
    chk("R3", {oe, inh, core_tx_en}, 3'b101);

    // R6 bypass
    #1 chk("R6", core_txd, 5'h0f);
    wr_reg(1, 8'h02);
    chk("R6", {five, core_txd, mii_rxd}, {1'b1, 5'h1f, 5'h1f});

    // R7 loopback disable alone
    wr_reg(1, 8'h01);
    chk("R7", loop_en, 0);
    wr_reg(1, 8'h00);
    chk("R7", loop_en, 1);

    // R4/R10 repeater forces, readback keeps stored bits
    wr_reg(0, 8'h03);
    rptr = 1; cyc(2);
    chk("R4", {aneg, fdx, spd, loop_en}, 4'b0010);
    chk_regs("R10");
    rptr = 0; cyc(2);
    chk_modes("R8");

    // R5 straps masked across a reset in repeater mode
    rptr = 1;
    do_reset(5'h03, 1, 1, 0);
    chk("R5", {aneg, fdx, spd, loop_en}, 4'b0010);
    s_aneg = 0; s_fdx = 0; s_spd = 1; cyc(2);
    chk("R5", {aneg, fdx, spd, loop_en}, 4'b0010);
    rptr = 0; cyc(2);
    chk("R8", {aneg, fdx, spd}, 3'b110);

    // random mix: R4 R6 R8 R9 R10 R3
    for (int i = 0; i < 400; i++) begin
      logic [1:0] a;
      a = 2'($urandom % 4);
      rptr = 1'($urandom);
      wr_reg(a, 8'($urandom));
      chk_modes("R8");
      txd = 5'($urandom); rxd = 5'($urandom); tx_en = 1'($urandom); #1;
      chk("R3", {core_txd, core_tx_en, mii_rxd}, exp_gate(m_ctrl[3], m_cfg[1], txd, tx_en, rxd));
      chk("R3", {oe, inh}, {~m_ctrl[3], m_ctrl[3]});
      if (i % 16 == 0) chk_regs("R10");
      @(negedge clk);
    end

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial void'($urandom(32'd2024));
endmodule